// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block holds a small shared word memory and tracks one reservation per hart so that several harts can build lock-free update loops on it. A hart issues a load-reserved to read a word and mark it as watched. Later it issues a store-conditional to the same word. The store lands only if nothing has touched the watched word in the meantime. Because any conflicting access clears the watch, even a write of the same value, an intervening change-and-restore is still detected.

Each hart has its own request lane. A fixed-priority arbiter grants one request per cycle, and the granted request gets a registered response on the next cycle. A separate snoop input carries writes and other watch-breaking accesses from agents outside the harts. Those accesses clear any reservation on the matching address. The memory is written in a form that maps onto a block RAM with a read-first port.

Top module: `lrsc_monitor`

## Requirements
- R1: At most one hart is granted per cycle, and the lowest-indexed hart with a pending request always wins. A hart's `req_ready` bit is high only while its `req_valid` is high. A granted request produces exactly one response, one clock later, on that hart's bit of `rsp_valid`.
- R2: The operation code is `req_op` = 0 for a plain load, 1 for a plain store, 2 for a load-reserved and 3 for a store-conditional. A plain load returns the addressed word on `rsp_rdata`, and a plain store writes `req_wdata` to that word.
- R3: A load-reserved returns the addressed word and marks that hart's reservation valid for that address.
- R4: A store-conditional whose hart holds a valid reservation for the same address writes the word and responds with `rsp_fail` = 0.
- R5: Any other store-conditional leaves memory unchanged and responds with `rsp_fail` = 1. Responses to operations other than a store-conditional always carry `rsp_fail` = 0.
- R6: Every store-conditional clears the issuing hart's own reservation, whether or not it succeeds.
- R7: A successful store-conditional clears the reservation of every other hart that watches the same address.
- R8: A plain store by one hart clears other harts' reservations on that address, even when it writes the value already there. A hart's own plain store and any plain load leave reservations intact.
- R9: A snoop (`snp_valid` high) clears every hart's reservation on `snp_addr` and leaves reservations on other addresses alone. A snoop in the same cycle as a granted request takes effect first, so a store-conditional to that address fails.
- R10: A new load-reserved replaces the hart's previous reservation, so a store-conditional to the old address fails.
- R11: Requests from several harts in the same cycle are served one per cycle in index order. The clearing caused by an earlier one is seen by the next, so two competing store-conditionals to one address give one success (the lower index) and one failure.
- R12: After reset, `rsp_valid` is zero and no reservation is held, so a store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NHART | Per-hart request present |
| req_op | input | 2*NHART | Per-hart operation code, hart h at bits [2h+1:2h] |
| req_addr | input | AW*NHART | Per-hart word address |
| req_wdata | input | DW*NHART | Per-hart store data |
| req_ready | output | NHART | Grant; the request is taken at this clock edge |
| snp_valid | input | 1 | External reservation-clearing access present |
| snp_addr | input | AW | Address of the external access |
| rsp_valid | output | NHART | One-hot response strobe, one cycle after the grant |
| rsp_rdata | output | DW | Word read for a load or load-reserved |
| rsp_fail | output | 1 | Store-conditional status: 0 success, 1 failure |

## Verification
Store-conditionals are tried after a matching load-reserved, with no reservation, against a different address, after the hart's own earlier store-conditional, and after a replacing load-reserved. Each of these separates the address compare from the valid flag. Intervening accesses come from another hart's plain store of an unchanged value, another hart's winning store-conditional, a snoop alone, and a snoop in the same cycle. These show that clearing depends on an access taking place and not on the value, and they fix the ordering. Control cases use the hart's own plain store, a foreign plain load and a snoop to an unrelated address, which must not clear anything. Simultaneous requests from both harts check the serial order and that the winner's clearing is visible to the second request.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'd0,
    OP_ST = 2'd1,
    OP_LR = 2'd2,
    OP_SC = 2'd3
  } op_e;
endpackage

// File: rtl/lrsc_arb.sv
module lrsc_arb #(
  parameter int NHART = 2,
  localparam int HW = (NHART > 1) ? $clog2(NHART) : 1
) (
  input  logic [NHART-1:0] req,
  output logic [NHART-1:0] gnt,
  output logic             gnt_any,
  output logic [HW-1:0]    gnt_idx
);
  always_comb begin
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int i = NHART - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_idx = HW'(i);
        gnt_any = 1'b1;
      end
    end
    gnt = '0;
    if (gnt_any) gnt[gnt_idx] = 1'b1;
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv
  import lrsc_pkg::*;
#(
  parameter int NHART = 2,
  parameter int AW    = 6,
  localparam int HW = (NHART > 1) ? $clog2(NHART) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                snp_valid,
  input  logic [AW-1:0]       snp_addr,
  input  logic                gnt_any,
  input  logic [HW-1:0]       gnt_idx,
  input  op_e                 gnt_op,
  input  logic [AW-1:0]       gnt_addr,
  output logic                sc_ok,
  output logic [NHART-1:0]    resv_vld,
  output logic [NHART*AW-1:0] resv_addr
);
  // reservations as seen after this cycle's snoop has been applied
  logic [NHART-1:0] vld_post_snp;
  logic             foreign_wr;

  always_comb begin
    for (int i = 0; i < NHART; i++) begin
      vld_post_snp[i] = resv_vld[i] &
        ~(snp_valid && (resv_addr[i*AW +: AW] == snp_addr));
    end
    sc_ok = gnt_any && (gnt_op == OP_SC) && vld_post_snp[gnt_idx] &&
            (resv_addr[gnt_idx*AW +: AW] == gnt_addr);
    foreign_wr = gnt_any && ((gnt_op == OP_ST) || sc_ok);
  end

  for (genvar g = 0; g < NHART; g++) begin : g_hart
    logic self_sel;
    logic hit;
    assign self_sel = gnt_any && (gnt_idx == HW'(g));
    assign hit      = resv_addr[g*AW +: AW] == gnt_addr;

    always_ff @(posedge clk) begin
      if (rst) begin
        resv_vld[g]           <= 1'b0;
        resv_addr[g*AW +: AW] <= '0;
      end else if (self_sel && gnt_op == OP_LR) begin
        resv_vld[g]           <= 1'b1;
        resv_addr[g*AW +: AW] <= gnt_addr;
      end else if (self_sel && gnt_op == OP_SC) begin
        resv_vld[g] <= 1'b0;
      end else if (!self_sel && foreign_wr && hit) begin
        resv_vld[g] <= 1'b0;
      end else begin
        resv_vld[g] <= vld_post_snp[g];
      end
    end
  end
endmodule

// File: rtl/lrsc_mem.sv
module lrsc_mem #(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store_q [DEPTH];

  // read-first single port, maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
    rdata <= store_q[addr];
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int NHART = 2,
  parameter int AW    = 6,
  parameter int DW    = 16,
  localparam int HW = (NHART > 1) ? $clog2(NHART) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NHART-1:0]    req_valid,
  input  logic [2*NHART-1:0]  req_op,
  input  logic [AW*NHART-1:0] req_addr,
  input  logic [DW*NHART-1:0] req_wdata,
  output logic [NHART-1:0]    req_ready,
  input  logic                snp_valid,
  input  logic [AW-1:0]       snp_addr,
  output logic [NHART-1:0]    rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_fail
);
  logic             gnt_any;
  logic [HW-1:0]    gnt_idx;
  op_e              gnt_op;
  logic [AW-1:0]    gnt_addr;
  logic [DW-1:0]    gnt_wdata;
  logic             sc_ok;
  logic             mem_we;
  logic [NHART-1:0]    resv_vld;
  logic [NHART*AW-1:0] resv_addr;

  lrsc_arb #(.NHART(NHART)) u_arb (
    .req     (req_valid),
    .gnt     (req_ready),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  assign gnt_op    = op_e'(req_op[gnt_idx*2 +: 2]);
  assign gnt_addr  = req_addr[gnt_idx*AW +: AW];
  assign gnt_wdata = req_wdata[gnt_idx*DW +: DW];

  lrsc_resv #(.NHART(NHART), .AW(AW)) u_resv (
    .clk       (clk),
    .rst       (rst),
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr),
    .gnt_any   (gnt_any),
    .gnt_idx   (gnt_idx),
    .gnt_op    (gnt_op),
    .gnt_addr  (gnt_addr),
    .sc_ok     (sc_ok),
    .resv_vld  (resv_vld),
    .resv_addr (resv_addr)
  );

  assign mem_we = gnt_any && ((gnt_op == OP_ST) || sc_ok);

  lrsc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (gnt_addr),
    .wdata (gnt_wdata),
    .rdata (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_fail  <= 1'b0;
    end else begin
      rsp_valid <= req_ready;
      rsp_fail  <= gnt_any && (gnt_op == OP_SC) && !sc_ok;
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int NHART = 2,
  parameter int AW    = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [NHART-1:0]    req_valid,
  input logic [2*NHART-1:0]  req_op,
  input logic [AW*NHART-1:0] req_addr,
  input logic [NHART-1:0]    req_ready,
  input logic                snp_valid,
  input logic [AW-1:0]       snp_addr,
  input logic [NHART-1:0]    rsp_valid,
  input logic                rsp_fail,
  input logic [NHART-1:0]    resv_vld
);
  a_r1_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));
  a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);
  a_r1_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    req_valid[0] |-> req_ready[0]);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rsp_valid == $past(req_ready));
  a_r5_fail_has_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_fail |-> (rsp_valid != '0));

  for (genvar g = 0; g < NHART; g++) begin : g_h
    logic          is_sc, is_lr, snp_hit;
    assign is_sc   = req_op[2*g +: 2] == 2'd3;
    assign is_lr   = req_op[2*g +: 2] == 2'd2;
    assign snp_hit = snp_valid && (snp_addr == req_addr[g*AW +: AW]);

    a_r5_plain_no_fail: assert property (@(posedge clk) disable iff (rst)
      (req_ready[g] && !is_sc) |=> !rsp_fail);
    a_r6_own_clear: assert property (@(posedge clk) disable iff (rst)
      (req_ready[g] && is_sc) |=> !resv_vld[g]);
    a_r3_lr_sets: assert property (@(posedge clk) disable iff (rst)
      (req_ready[g] && is_lr && !snp_hit) |=> resv_vld[g]);
    a_r9_snoop_first: assert property (@(posedge clk) disable iff (rst)
      (req_ready[g] && is_sc && snp_hit) |=> rsp_fail);
  end
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NHART(NHART), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .req_ready (req_ready),
  .snp_valid (snp_valid),
  .snp_addr  (snp_addr),
  .rsp_valid (rsp_valid),
  .rsp_fail  (rsp_fail),
  .resv_vld  (resv_vld)
);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
  localparam int N  = 2;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int LD = 0, ST = 1, LR = 2, SC = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    req_ready;
  logic            snp_valid = 1'b0;
  logic [AW-1:0]   snp_addr = '0;
  logic [N-1:0]    rsp_valid;
  logic [DW-1:0]   rsp_rdata;
  logic            rsp_fail;

  always #10 clk = ~clk;

  lrsc_monitor #(.NHART(N), .AW(AW), .DW(DW)) u0 (.*);

  typedef struct {
    int          hart;
    logic [DW-1:0] data;
    bit          chk_data;
    bit          fail;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [1 << AW];
  bit            m_v [N];
  logic [AW-1:0] m_a [N];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model: snoop first, then the granted request
  function automatic void model(int h, int op, logic [AW-1:0] a,
                                logic [DW-1:0] wd, bit sv,
                                logic [AW-1:0] sa, string tag);
    exp_t e;
    bit ok;
    for (int i = 0; i < N; i++) if (sv && m_v[i] && m_a[i] == sa) m_v[i] = 0;
    e.hart = h; e.data = '0; e.chk_data = 0; e.fail = 0; e.tag = tag;
    case (op)
      LD: begin e.data = m_mem[a]; e.chk_data = 1; end
      ST: begin
        m_mem[a] = wd;
        for (int i = 0; i < N; i++) if (i != h && m_v[i] && m_a[i] == a) m_v[i] = 0;
      end
      LR: begin e.data = m_mem[a]; e.chk_data = 1; m_v[h] = 1; m_a[h] = a; end
      default: begin
        ok = m_v[h] && m_a[h] == a;
        m_v[h] = 0;
        if (ok) begin
          m_mem[a] = wd;
          for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) m_v[i] = 0;
        end
        e.fail = !ok;
      end
    endcase
    sbq.push_back(e);
  endfunction

  task automatic clear_inputs();
    req_valid = '0;
    snp_valid = 1'b0;
  endtask

  task automatic set_lane(int h, int op, logic [AW-1:0] a, logic [DW-1:0] wd);
    req_valid[h]           = 1'b1;
    req_op[2*h +: 2]       = 2'(op);
    req_addr[h*AW +: AW]   = a;
    req_wdata[h*DW +: DW]  = wd;
  endtask

  task automatic issue(int h, int op, logic [AW-1:0] a, logic [DW-1:0] wd,
                       string tag, bit sv = 0, logic [AW-1:0] sa = '0);
    @(negedge clk);
    set_lane(h, op, a, wd);
    snp_valid = sv;
    snp_addr  = sa;
    model(h, op, a, wd, sv, sa, tag);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic snoop(logic [AW-1:0] sa);
    @(negedge clk);
    snp_valid = 1'b1;
    snp_addr  = sa;
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == sa) m_v[i] = 0;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic dual(int op0, logic [AW-1:0] a0, logic [DW-1:0] w0,
                      int op1, logic [AW-1:0] a1, logic [DW-1:0] w1, string tag);
    @(negedge clk);
    set_lane(0, op0, a0, w0);
    set_lane(1, op1, a1, w1);
    model(0, op0, a0, w0, 0, '0, tag);
    model(1, op1, a1, w1, 0, '0, tag);
    #1 check(req_ready == 2'b01, "R1", "first grant", int'(req_ready), 1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1 check(req_ready == 2'b10, "R11", "second grant", int'(req_ready), 2);
    @(negedge clk);
    clear_inputs();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid != '0) begin
      if (sbq.size() == 0) begin
        check(0, "R1", "unexpected response", int'(rsp_valid), 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(rsp_valid == N'(1 << e.hart), e.tag, "rsp_valid",
              int'(rsp_valid), 1 << e.hart);
        check(rsp_fail == e.fail, e.tag, "rsp_fail", int'(rsp_fail), int'(e.fail));
        if (e.chk_data)
          check(rsp_rdata == e.data, e.tag, "rsp_rdata", int'(rsp_rdata), int'(e.data));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      check(0, "WDOG", "timeout", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == '0, "R12", "rsp_valid after reset", int'(rsp_valid), 0);
    check(req_ready == '0, "R12", "req_ready after reset", int'(req_ready), 0);

    // preload (R2 plain stores)
    for (int a = 0; a < 32; a++) issue(a % 2, ST, AW'(a), DW'(16'h1000 + a), "R2");
    // R12: no reservation after reset
    issue(0, SC, 6'd3, 16'hdead, "R12");
    issue(1, LD, 6'd3, 0, "R5");
    // R2 plain load
    issue(1, LD, 6'd5, 0, "R2");
    // R3 R4 basic pair
    issue(0, LR, 6'd5, 0, "R3");
    issue(0, SC, 6'd5, 16'h2222, "R4");
    issue(1, LD, 6'd5, 0, "R4");
    // R6 second SC without new LR
    issue(0, SC, 6'd5, 16'h9999, "R6");
    issue(0, LD, 6'd5, 0, "R6");
    // R7 winning SC cancels other hart
    issue(0, LR, 6'd6, 0, "R3");
    issue(1, LR, 6'd6, 0, "R3");
    issue(1, SC, 6'd6, 16'h3333, "R7");
    issue(0, SC, 6'd6, 16'h4444, "R7");
    issue(0, LD, 6'd6, 0, "R7");
    // R9 external snoop
    issue(0, LR, 6'd7, 0, "R3");
    snoop(6'd7);
    issue(0, SC, 6'd7, 16'h5555, "R9");
    issue(0, LR, 6'd13, 0, "R3");
    snoop(6'd14);
    issue(0, SC, 6'd13, 16'h5656, "R9");
    // R8 foreign store of same value
    issue(0, LR, 6'd8, 0, "R3");
    issue(1, ST, 6'd8, 16'h1008, "R8");
    issue(0, SC, 6'd8, 16'h6666, "R8");
    issue(0, LD, 6'd8, 0, "R8");
    // R8 own store and foreign load keep reservations
    issue(0, LR, 6'd22, 0, "R3");
    issue(0, ST, 6'd22, 16'h0505, "R8");
    issue(0, SC, 6'd22, 16'h0606, "R8");
    issue(1, LR, 6'd23, 0, "R3");
    issue(0, LD, 6'd23, 0, "R8");
    issue(1, SC, 6'd23, 16'h0707, "R8");
    // R10 replacement
    issue(0, LR, 6'd9, 0, "R10");
    issue(0, LR, 6'd10, 0, "R10");
    issue(0, SC, 6'd9, 16'h7777, "R10");
    issue(0, LD, 6'd9, 0, "R10");
    issue(0, LR, 6'd9, 0, "R10");
    issue(0, LR, 6'd10, 0, "R10");
    issue(0, SC, 6'd10, 16'h7878, "R10");
    // R5 address mismatch
    issue(1, LR, 6'd11, 0, "R3");
    issue(1, SC, 6'd12, 16'h8888, "R5");
    issue(1, LD, 6'd12, 0, "R5");
    // R11 simultaneous competing SCs
    dual(LR, 6'd20, 0, LR, 6'd20, 0, "R11");
    dual(SC, 6'd20, 16'haaaa, SC, 6'd20, 16'hbbbb, "R11");
    issue(1, LD, 6'd20, 0, "R11");
    // R9 snoop in the same cycle as SC
    issue(0, LR, 6'd21, 0, "R3");
    issue(0, SC, 6'd21, 16'hcccc, "R9", 1'b1, 6'd21);
    issue(0, LD, 6'd21, 0, "R9");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R1", "responses outstanding", sbq.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule